// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a bus-attached system timer whose time base is a 32768 Hz slow clock, asynchronous to the bus clock. It holds a free-running real-time counter (20 bits by default) advanced through a programmable prescaler. It also has an alarm that matches against an absolute counter value and a period interval timer that flags every N slow-clock ticks. Four event flags sit in a status register that clears when read. Each flag can raise a single shared interrupt line through a mask. The mask is altered only through a set-only register and a clear-only register.

The slow clock is not used as a clock. It passes through a synchronizer into the bus domain, and each of its rising edges becomes a one-cycle tick there. All state therefore lives in one clock domain, and a single counter read always returns a coherent value. The bus is a plain single-cycle port: a read returns data combinationally in the cycle of the strobe, and any side effect of a read or write takes place at the clock edge that ends that cycle. The bus clock must run at more than twice the slow-clock rate.

Word map (offset on `bus_addr`): 0 prescaler, 1 period, 2 alarm, 3 counter (read-only), 4 status (read-only, clear-on-read), 5 enable-set (write-only), 6 enable-clear (write-only), 7 mask (read-only). Status and mask bits: bit 0 interval, bit 1 watchdog overflow, bit 2 counter increment, bit 3 alarm.

Top module: `st_timer`

## Requirements
- R1: After reset, the prescaler reads PRE_RESET (default 32768), and the period, alarm, counter, status and mask registers read 0. `irq` is low.
- R2: With prescaler value P, the counter advances by one on every P-th slow-clock rising edge. P = 0 means 2^PRE_W. Writing the prescaler restarts the prescaler phase from zero and leaves the counter value unchanged.
- R3: The counter wraps from 2^CNT_W - 1 to 0.
- R4: Status bit 2 is set on every counter increment.
- R5: Status bit 3 is set when the counter steps onto the alarm value. An alarm equal to the current counter value matches only after a full wrap of 2^CNT_W increments.
- R6: Writing the alarm register clears a pending alarm flag (bit 3).
- R7: With period value V, status bit 0 is set every V slow-clock ticks, repeating. V = 0 means 2^PIT_W. Writing the period register restarts the interval count from zero.
- R8: A status read returns the pending flags and clears them. A flag whose event lands in the same cycle as the read stays set. Bit 1 (watchdog) always reads 0.
- R9: Writing offset 5 sets the mask bits given as ones, and writing offset 6 clears them. Zero bits leave the mask unchanged. The mask reads back at offset 7.
- R10: `irq` is high exactly when some status bit and its mask bit are both set. It falls in the cycle after a status read that leaves no enabled flag pending.
- R11: The counter changes only on a synchronized slow-clock tick, and by at most one per bus cycle, so any single read is coherent.
- R12: Writes to offsets 3, 4 and 7 have no effect. Reads of offsets 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | 32768 Hz time base, asynchronous to clk |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses a reduced configuration (6-bit counter, 4-bit prescaler and period) so that wraps and zero-means-maximum settings can be reached. The counter is swept tick by tick under prescaler values 0 through 5, which separates the prescaler phase restart from counter restarts and exposes an off-by-one in the divide. The alarm is placed at every distance from 1 to 5 ticks and at distance zero, which distinguishes a match on the step from a match on level. The period timer is swept over values 0 through 5 with a restart mid-interval. A tick is deliberately aligned with a status read to show that read-clear does not swallow a simultaneous event.

// File: rtl/st_pkg.sv
// Package: shared register offsets and status-bit positions for the
// slow-clock system timer. Assumes a 32-bit data bus, word addressing.
package st_pkg;

    localparam int ST_DATA_W = 32;
    localparam int ST_ADDR_W = 3;
    localparam int ST_NFLAGS = 4;

    // Status/mask bit positions (software decodes these)
    localparam int FLG_PIT  = 0;
    localparam int FLG_WDOG = 1;
    localparam int FLG_INC  = 2;
    localparam int FLG_ALM  = 3;

    typedef enum logic [ST_ADDR_W-1:0] {
        REG_PRESCALE = 3'd0,
        REG_PERIOD   = 3'd1,
        REG_ALARM    = 3'd2,
        REG_COUNT    = 3'd3,
        REG_STATUS   = 3'd4,
        REG_IEN_SET  = 3'd5,
        REG_IEN_CLR  = 3'd6,
        REG_MASK     = 3'd7
    } st_reg_e;

endpackage

// File: rtl/st_tick_sync.sv
// st_tick_sync: brings the asynchronous slow clock into the bus domain
// through STAGES flops and emits a one-cycle pulse per rising edge.
// Assumes the bus clock is more than twice the slow-clock frequency.
module st_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);

    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    // Shift the slow clock level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], slow_clk};
        end
    end

    // Rising edge of the synchronized level
    assign tick = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/st_rtc.sv
// st_rtc: prescaler and free-running real-time counter with an
// absolute-match alarm. The counter advances once every pre_val ticks
// (0 = 2^PRE_W). The alarm event fires when the counter steps onto
// alarm_val; a write to the alarm in the same cycle cancels it.
// Assumes tick is a single-cycle pulse in the clk domain.
module st_rtc #(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             pre_restart,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             alarm_wr,
    output logic [CNT_W-1:0] count,
    output logic             inc_evt,
    output logic             alm_evt
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] div_last;
    logic [CNT_W-1:0] count_nxt;
    logic             step;

    assign div_last  = pre_val - PRE_W'(1);
    assign step      = tick && !pre_restart && (div_q == div_last);
    assign count_nxt = count + CNT_W'(1);

    // Prescaler phase: restarts on a prescaler write, wraps on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (pre_restart) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= step ? '0 : div_q + PRE_W'(1);
        end
    end

    // Real-time counter: advances on each prescaler step, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= count_nxt;
        end
    end

    assign inc_evt = step;
    assign alm_evt = step && !alarm_wr && (count_nxt == alarm_val);

endmodule

// File: rtl/st_pit.sv
// st_pit: period interval timer. Emits pit_evt on every period_val-th
// tick (0 = 2^PIT_W). A restart (period write) clears the phase.
// Assumes tick is a single-cycle pulse in the clk domain.
module st_pit #(
    parameter int PIT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PIT_W-1:0] period_val,
    input  logic             restart,
    output logic             pit_evt
);

    logic [PIT_W-1:0] phase_q;
    logic [PIT_W-1:0] phase_last;

    assign phase_last = period_val - PIT_W'(1);
    assign pit_evt    = tick && !restart && (phase_q == phase_last);

    // Interval phase counter: cleared on restart, wraps on each event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= pit_evt ? '0 : phase_q + PIT_W'(1);
        end
    end

endmodule

// File: rtl/st_status.sv
// st_status: sticky event flags with clear-on-read, a set/clear-only
// interrupt mask and the combined interrupt. A new event in the cycle of
// a clear wins over the clear. Assumes set and clear mask writes never
// coincide (they use different offsets).
module st_status #(
    parameter int NF      = 4,
    parameter int ALM_IDX = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] events,
    input  logic          rd_clr,
    input  logic          alm_clr,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic [NF-1:0] wflags,
    output logic [NF-1:0] status,
    output logic [NF-1:0] mask,
    output logic          irq
);

    logic [NF-1:0] drop;

    // Bits to clear this cycle: everything on a read, the alarm bit on an alarm write
    always_comb begin
        drop = rd_clr ? '1 : '0;
        if (alm_clr) begin
            drop[ALM_IDX] = 1'b1;
        end
    end

    // Sticky flags: clear requested bits, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~drop) | events;
        end
    end

    // Interrupt mask: set-only and clear-only updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (en_set) begin
            mask <= mask | wflags;
        end else if (en_clr) begin
            mask <= mask & ~wflags;
        end
    end

    // Combined interrupt from enabled pending flags
    assign irq = |(status & mask);

endmodule

// File: rtl/st_timer.sv
// st_timer: top of the slow-clock system timer. Decodes the word-mapped
// register port, holds the prescaler/period/alarm settings and ties the
// synchronizer, counter, interval timer and status logic together.
// Assumes clk is more than twice slow_clk; rst_n is synchronous and held
// for at least STAGES+1 cycles.
module st_timer #(
    parameter int CNT_W     = 20,
    parameter int PRE_W     = 16,
    parameter int PIT_W     = 16,
    parameter int PRE_RESET = 32768,
    parameter int STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import st_pkg::*;

    localparam int NF = ST_NFLAGS;

    st_reg_e          reg_sel;
    logic             wr_pre, wr_per, wr_alarm, wr_ien, wr_idis, rd_stat;
    logic [PRE_W-1:0] pre_q;
    logic [PIT_W-1:0] per_q;
    logic [CNT_W-1:0] alm_q;
    logic [CNT_W-1:0] count;
    logic             tick, inc_evt, alm_evt, pit_evt;
    logic [NF-1:0]    events;
    logic [NF-1:0]    status;
    logic [NF-1:0]    mask;
    logic             unused_wdata;

    assign reg_sel  = st_reg_e'(bus_addr);
    assign wr_pre   = bus_sel &&  bus_wr && (reg_sel == REG_PRESCALE);
    assign wr_per   = bus_sel &&  bus_wr && (reg_sel == REG_PERIOD);
    assign wr_alarm = bus_sel &&  bus_wr && (reg_sel == REG_ALARM);
    assign wr_ien   = bus_sel &&  bus_wr && (reg_sel == REG_IEN_SET);
    assign wr_idis  = bus_sel &&  bus_wr && (reg_sel == REG_IEN_CLR);
    assign rd_stat  = bus_sel && !bus_wr && (reg_sel == REG_STATUS);
    assign unused_wdata = ^bus_wdata;

    // Settings registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_W'(PRE_RESET);
            per_q <= '0;
            alm_q <= '0;
        end else begin
            if (wr_pre)   pre_q <= bus_wdata[PRE_W-1:0];
            if (wr_per)   per_q <= bus_wdata[PIT_W-1:0];
            if (wr_alarm) alm_q <= bus_wdata[CNT_W-1:0];
        end
    end

    st_tick_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_clk (slow_clk),
        .tick     (tick)
    );

    st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rtc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .pre_val     (pre_q),
        .pre_restart (wr_pre),
        .alarm_val   (alm_q),
        .alarm_wr    (wr_alarm),
        .count       (count),
        .inc_evt     (inc_evt),
        .alm_evt     (alm_evt)
    );

    st_pit #(.PIT_W(PIT_W)) u_pit (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .period_val (per_q),
        .restart    (wr_per),
        .pit_evt    (pit_evt)
    );

    // Event vector in status-bit order; the watchdog bit has no source
    always_comb begin
        events           = '0;
        events[FLG_PIT]  = pit_evt;
        events[FLG_WDOG] = 1'b0;
        events[FLG_INC]  = inc_evt;
        events[FLG_ALM]  = alm_evt;
    end

    st_status #(.NF(NF), .ALM_IDX(FLG_ALM)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .rd_clr  (rd_stat),
        .alm_clr (wr_alarm),
        .en_set  (wr_ien),
        .en_clr  (wr_idis),
        .wflags  (bus_wdata[NF-1:0]),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    // Read data mux, combinational in the strobe cycle
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (reg_sel)
                REG_PRESCALE: bus_rdata = ST_DATA_W'(pre_q);
                REG_PERIOD:   bus_rdata = ST_DATA_W'(per_q);
                REG_ALARM:    bus_rdata = ST_DATA_W'(alm_q);
                REG_COUNT:    bus_rdata = ST_DATA_W'(count);
                REG_STATUS:   bus_rdata = ST_DATA_W'(status);
                REG_MASK:     bus_rdata = ST_DATA_W'(mask);
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/st_timer_chk.sv
// st_timer_chk: property checker bound into st_timer. Observes the tick,
// counter, flags and mask and the decoded bus strobes.
module st_timer_chk #(
    parameter int CNT_W = 20,
    parameter int NF    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [NF-1:0]    status,
    input logic [NF-1:0]    mask,
    input logic [NF-1:0]    events,
    input logic             rd_stat,
    input logic             wr_alarm,
    input logic             wr_ien,
    input logic             wr_idis,
    input logic [NF-1:0]    wflags
);

    // R11: counter holds or advances by exactly one per cycle
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

    // R2: counter moves only after a synchronized tick
    a_r2_move_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> $past(tick));

    // R8: status read with no concurrent event leaves all flags clear
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_stat) && ($past(events) == '0)) |-> (status == '0));

    // R8: watchdog flag is never set
    a_r8_wdog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1]);

    // R6: alarm write leaves no pending alarm flag
    a_r6_alarm_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_alarm) |-> !status[3]);

    // R9: set-only write turns on every requested mask bit
    a_r9_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ien) |-> ((mask & $past(wflags)) == $past(wflags)));

    // R9: clear-only write turns off every requested mask bit
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_idis) |-> ((mask & $past(wflags)) == '0));

endmodule

bind st_timer st_timer_chk #(.CNT_W(CNT_W), .NF(4)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .status   (status),
    .mask     (mask),
    .events   (events),
    .rd_stat  (rd_stat),
    .wr_alarm (wr_alarm),
    .wr_ien   (wr_ien),
    .wr_idis  (wr_idis),
    .wflags   (bus_wdata[3:0])
);

// File: tb/st_timer_tb.sv
module st_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 6;
    localparam int PW = 4;
    localparam int TW = 4;
    localparam int PRE_RST = 8;
    localparam int WRAP = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    st_timer #(.CNT_W(CW), .PRE_W(PW), .PIT_W(TW), .PRE_RESET(PRE_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // One slow-clock period; the tick commits at the third rising bus edge
    task automatic slow_tick();
        @(negedge clk); slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        int c;
        int v1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(0, v); check("R1 prescaler", v, PRE_RST);
        rd(1, v); check("R1 period", v, 0);
        rd(2, v); check("R1 alarm", v, 0);
        rd(3, v); check("R1 counter", v, 0);
        rd(4, v); check("R1 status", v, 0);
        rd(7, v); check("R1 mask", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2: prescaler 1, one step per tick
        wr(0, 1);
        for (int k = 1; k <= 10; k++) begin
            slow_tick(); rd(3, v); check("R2 p=1 count", v, k);
        end
        // R2: prescaler sweep, phase restarts on write
        for (int p = 2; p <= 5; p++) begin
            slow_tick();
            wr(0, p);
            rd(3, v); base = int'(v);
            for (int k = 1; k <= 2*p+1; k++) begin
                slow_tick(); rd(3, v);
                check("R2 sweep count", v, 32'((base + k/p) % WRAP));
            end
        end
        // R2: prescaler 0 means 2^PW
        wr(0, 0);
        rd(3, v); base = int'(v);
        for (int k = 1; k <= (1 << PW); k++) begin
            slow_tick(); rd(3, v);
            check("R2 p=0 count", v, 32'((base + k/(1 << PW)) % WRAP));
        end

        // R3: wrap of the counter
        wr(0, 1);
        rd(3, v); base = int'(v);
        for (int k = 1; k <= WRAP + 6; k++) begin
            slow_tick(); rd(3, v);
            check("R3 wrap count", v, 32'((base + k) % WRAP));
        end

        // R4: increment flag follows the prescaler
        wr(0, 3);
        rd(4, v);
        for (int k = 1; k <= 6; k++) begin
            slow_tick(); rd(4, v);
            check("R4 inc flag", 32'(v[2]), 32'((k % 3) == 0));
        end

        // R5: alarm at distance 1..5
        wr(0, 1);
        for (int d = 1; d <= 5; d++) begin
            rd(3, v); c = int'(v);
            wr(2, 32'((c + d) % WRAP));
            rd(4, v);
            for (int k = 1; k <= d; k++) begin
                slow_tick(); rd(4, v);
                check("R5 alarm distance", 32'(v[3]), 32'(k == d));
            end
        end
        // R5: alarm equal to current count needs a full wrap
        rd(3, v); c = int'(v);
        wr(2, 32'(c));
        for (int k = 1; k <= WRAP; k++) begin
            slow_tick(); rd(4, v);
            check("R5 alarm wrap", 32'(v[3]), 32'(k == WRAP));
        end

        // R6: alarm write cancels a pending alarm (seen on irq)
        wr(5, 32'h8);
        rd(3, v); c = int'(v);
        wr(2, 32'((c + 1) % WRAP));
        slow_tick();
        check("R6 alarm pending irq", 32'(irq), 1);
        wr(2, 32'((c + 40) % WRAP));
        check("R6 irq after alarm write", 32'(irq), 0);
        rd(4, v); check("R6 alarm flag cleared", 32'(v[3]), 0);
        wr(6, 32'hF);

        // R7: interval sweep, V = 1..5
        for (int pv = 1; pv <= 5; pv++) begin
            wr(1, pv);
            rd(4, v);
            for (int k = 1; k <= 3*pv; k++) begin
                slow_tick(); rd(4, v);
                check("R7 interval flag", 32'(v[0]), 32'((k % pv) == 0));
            end
        end
        // R7: V = 0 means 2^TW
        wr(1, 0);
        rd(4, v);
        for (int k = 1; k <= (1 << TW); k++) begin
            slow_tick(); rd(4, v);
            check("R7 interval zero", 32'(v[0]), 32'(k == (1 << TW)));
        end
        // R7: period write restarts the count
        wr(1, 4);
        for (int k = 0; k < 3; k++) slow_tick();
        wr(1, 4);
        rd(4, v);
        for (int k = 1; k <= 4; k++) begin
            slow_tick(); rd(4, v);
            check("R7 restart", 32'(v[0]), 32'(k == 4));
        end
        wr(1, 0);

        // R8: read returns flags and clears; watchdog bit zero
        slow_tick();
        rd(4, v); check("R8 flag present", 32'(v[2]), 1);
        check("R8 watchdog bit", 32'(v[1]), 0);
        rd(4, v); check("R8 cleared after read", 32'(v[2]), 0);
        // R8: event in the read cycle survives the clear
        @(negedge clk); slow_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd4;
        #1 v = bus_rdata;
        check("R8 same-cycle read value", 32'(v[2]), 0);
        @(negedge clk); bus_sel = 1'b0;
        repeat (3) @(negedge clk); slow_clk = 1'b0;
        repeat (3) @(negedge clk);
        rd(4, v); check("R8 same-cycle event kept", 32'(v[2]), 1);

        // R9: mask set/clear
        wr(5, 32'h5); rd(7, v); check("R9 set", v, 32'h5);
        wr(5, 32'h8); rd(7, v); check("R9 set more", v, 32'hD);
        wr(6, 32'h1); rd(7, v); check("R9 clear", v, 32'hC);
        wr(5, 32'h0); rd(7, v); check("R9 zero set", v, 32'hC);
        wr(6, 32'h0); rd(7, v); check("R9 zero clear", v, 32'hC);
        wr(6, 32'hF); rd(7, v); check("R9 clear all", v, 32'h0);

        // R10: irq follows enabled flags and drops after read
        rd(4, v);
        wr(5, 32'h4);
        check("R10 idle irq", 32'(irq), 0);
        slow_tick();
        check("R10 irq on enabled flag", 32'(irq), 1);
        rd(4, v);
        check("R10 irq after read", 32'(irq), 0);
        wr(6, 32'h4); wr(5, 32'h8);
        slow_tick();
        check("R10 masked flag no irq", 32'(irq), 0);
        wr(6, 32'hF);

        // R11: reads during a tick see c or c+1, never backwards
        rd(3, v); c = int'(v);
        @(negedge clk); slow_clk = 1'b1;
        for (int k = 0; k < 6; k++) begin
            rd(3, v); v1 = int'(v);
            check("R11 coherent read", 32'(v1 == c || v1 == (c + 1) % WRAP), 1);
        end
        slow_clk = 1'b0;
        repeat (3) @(negedge clk);
        rd(3, v); check("R11 one step", v, 32'((c + 1) % WRAP));
        rd(3, v); check("R11 stable", v, 32'((c + 1) % WRAP));
        c = (c + 1) % WRAP;

        // R12: read-only writes ignored, write-only reads zero
        wr(3, 32'h15); rd(3, v); check("R12 counter write ignored", v, 32'(c));
        wr(5, 32'h2);
        wr(7, 32'h0); rd(7, v); check("R12 mask write ignored", v, 32'h2);
        slow_tick();
        wr(4, 32'h0); rd(4, v); check("R12 status write ignored", 32'(v[2]), 1);
        rd(5, v); check("R12 enable reads zero", v, 0);
        rd(6, v); check("R12 disable reads zero", v, 0);

        summary();
        $finish;
    end

endmodule